// File: doc/BRIEF.md
# Linked-Descriptor DMA Copy Engine

This block is a single-channel copy engine that moves blocks of words between a near (local) address space and a far (remote) address space. Software does not program a transfer directly. It builds a linked list of six-word transfer records in near memory, writes the address of the first record to the link register, and enables the channel. The engine then fetches each record, copies the block the record describes, and follows the record's link word to the next record. A link of zero ends the chain.

The engine has one word-wide memory master port. It uses this port for record fetches and for data movement, and a space-select output marks accesses to the far space. A small register port gives control, write-one-to-clear status, and read access to the working copies of the current record. The interrupt output is raised while any status flag is set. End-of-transfer flags are gated per record, and a chain-resume control lets software append records to a chain that has already ended and continue from there.

Top module: `dmac_engine`

## Requirements
- R1: After reset the control word and the status word both read 0, `irq` is low and `mem_req` is low.
- R2: Writing the control word (register 0) with bit 0 set, while the channel is disabled and idle, loads the current-record register from the link register. The engine then reads six words from the near space at ascending word addresses, starting at that address. If the link register is zero, the chain-end flag is set at once and no access is made.
- R3: The six record words are, in order: link, far address low, far address high (held but not used), near address, byte count, record control. When record control bit 0 is 0, each word is read from the far space and written to the near space. When it is 1, the direction is reversed. Every word is a read followed by a write, and both addresses advance by 4 for each word.
- R4: When record control bit 6 is set, both the read and the write of each word go to the near space (`mem_space` = 0). The far address is then used as an address in the near space.
- R5: Only the low 24 bits of the byte count are kept, and the two lowest of those bits are ignored. A count that reduces to zero moves no data.
- R6: When a record's copy completes, status bit 9 (end of transfer) is set only if record control bit 4 is set.
- R7: When a record completes and its link is non-zero, the engine fetches the linked record. When the link is zero, status bit 8 (end of chain) is set and status bit 10 (active) clears.
- R8: Writing the control word with bits 0 and 1 both set, while the channel is enabled and idle, re-reads the link word of the current record. If that word is now non-zero, the engine fetches and runs that record. If it is still zero, the end-of-chain flag is set again.
- R9: An error response on the memory port halts the channel and clears the active bit. It also records the error kind in the status word: `mem_err_kind` 1 sets bit 2, kind 0 or 3 sets bit 3, and kind 2 sets bit 5.
- R10: Status bits 2, 3, 5, 8 and 9 stay set until a 1 is written to that bit of register 1. `irq` is high while any of these bits is set.
- R11: Registers 2 to 8 read back the current record address, the link, far low, far high, near address, remaining byte count and record control. Status bit 10 reads 1 while a chain is running. A write to the link register (register 3) is ignored while the engine is active.
- R12: `mem_req` stays high, with `mem_addr` and `mem_we` unchanged, until `mem_ack` or `mem_err` is seen with it.
- R13: Clearing control bit 0 while the engine is active stops the engine when the access in flight completes. No status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | High while any status flag is set |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_space | output | 1 | 1 selects the far space, 0 the near space |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access ended with an error |
| mem_err_kind | input | 2 | Error kind when `mem_err` is high |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
Chain resume is the hardest condition to reach from the ports. It needs a chain that has already ended, with the engine enabled but idle. The link word of the last record must also be changed in memory behind the engine. The bench reaches this condition in steps. It runs a one-record chain to its end and requests a resume while the link is still zero, which must only repeat the end-of-chain flag. It then patches that link in its memory model and requests a resume again. Error halts in the middle of a copy are set up by naming one address in the memory model that answers with an error of a chosen kind.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 6;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SRC,
        ST_DST,
        ST_RETIRE,
        ST_RELINK
    } dma_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] far_lo;
        logic [WORD_W-1:0] far_hi;
        logic [WORD_W-1:0] near_addr;
        logic [WORD_W-1:0] bytes;
        logic [WORD_W-1:0] ctl;
    } desc_t;

    typedef struct packed {
        logic tabt;
        logic mabt;
        logic iabt;
        logic chain;
        logic xfer;
    } flag_set_t;

    typedef enum logic [1:0] {
        ERR_MASTER   = 2'd0,
        ERR_TARGET   = 2'd1,
        ERR_INTERNAL = 2'd2,
        ERR_OTHER    = 2'd3
    } err_kind_e;

    // register word indices
    localparam logic [3:0] RG_CTRL  = 4'd0;
    localparam logic [3:0] RG_STAT  = 4'd1;
    localparam logic [3:0] RG_CUR   = 4'd2;
    localparam logic [3:0] RG_LINK  = 4'd3;
    localparam logic [3:0] RG_FARLO = 4'd4;
    localparam logic [3:0] RG_FARHI = 4'd5;
    localparam logic [3:0] RG_NEAR  = 4'd6;
    localparam logic [3:0] RG_BYTES = 4'd7;
    localparam logic [3:0] RG_DCTL  = 4'd8;

    // control, status and record-control bit positions
    localparam int CB_EN     = 0;
    localparam int CB_RESUME = 1;
    localparam int SB_TABT   = 2;
    localparam int SB_MABT   = 3;
    localparam int SB_IABT   = 5;
    localparam int SB_CHAIN  = 8;
    localparam int SB_XFER   = 9;
    localparam int SB_BUSY   = 10;
    localparam int DB_DIR    = 0;
    localparam int DB_IE     = 4;
    localparam int DB_M2M    = 6;

    function automatic logic [WORD_W-1:0] pack_status(flag_set_t f, logic busy);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[SB_TABT]  = f.tabt;
        w[SB_MABT]  = f.mabt;
        w[SB_IABT]  = f.iabt;
        w[SB_CHAIN] = f.chain;
        w[SB_XFER]  = f.xfer;
        w[SB_BUSY]  = busy;
        return w;
    endfunction

endpackage

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              resume_i,
    input  logic              link_wr_i,
    input  logic [WORD_W-1:0] link_wdata_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_space,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [1:0]        mem_err_kind,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy_o,
    output flag_set_t         set_o,
    output desc_t             desc_o,
    output logic [WORD_W-1:0] cur_o
);

    localparam logic [WORD_W-1:0] BYTE_MASK =
        WORD_W'((64'd1 << CNT_W) - 64'd1) & ~WORD_W'(3);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    dma_state_e        st_q;
    logic [IDX_W-1:0]  widx_q;
    logic [WORD_W-1:0] cur_q;
    logic [WORD_W-1:0] hold_q;
    desc_t             d_q;

    logic ok, bad, to_far, m2m;
    assign ok     = mem_req && mem_ack && !mem_err;
    assign bad    = mem_req && mem_err;
    assign to_far = d_q.ctl[DB_DIR];
    assign m2m    = d_q.ctl[DB_M2M];

    // memory port drive
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_space = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st_q)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + (WORD_W'(widx_q) << 2);
            end
            ST_RELINK: begin
                mem_req  = 1'b1;
                mem_addr = cur_q;
            end
            ST_SRC: begin
                mem_req   = 1'b1;
                mem_addr  = to_far ? d_q.near_addr : d_q.far_lo;
                mem_space = !to_far && !m2m;
            end
            ST_DST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = hold_q;
                mem_addr  = to_far ? d_q.far_lo : d_q.near_addr;
                mem_space = to_far && !m2m;
            end
            default: ;
        endcase
    end

    // flag set pulses
    always_comb begin
        set_o       = '0;
        set_o.tabt  = bad && (mem_err_kind == ERR_TARGET);
        set_o.mabt  = bad && ((mem_err_kind == ERR_MASTER) || (mem_err_kind == ERR_OTHER));
        set_o.iabt  = bad && (mem_err_kind == ERR_INTERNAL);
        set_o.xfer  = (st_q == ST_RETIRE) && d_q.ctl[DB_IE];
        set_o.chain = ((st_q == ST_RETIRE) && (d_q.link == '0))
                   || (ok && (st_q == ST_RELINK) && (mem_rdata == '0))
                   || ((st_q == ST_IDLE) && start_i && (d_q.link == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            widx_q <= '0;
            cur_q  <= '0;
            hold_q <= '0;
            d_q    <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (d_q.link != '0) begin
                            cur_q  <= d_q.link;
                            widx_q <= '0;
                            st_q   <= ST_FETCH;
                        end
                    end else if (resume_i) begin
                        st_q <= ST_RELINK;
                    end else if (link_wr_i) begin
                        d_q.link <= link_wdata_i;
                    end
                end
                ST_FETCH: begin
                    if (bad) begin
                        st_q <= ST_IDLE;
                    end else if (ok) begin
                        unique case (widx_q)
                            IDX_W'(0): d_q.link      <= mem_rdata;
                            IDX_W'(1): d_q.far_lo    <= mem_rdata;
                            IDX_W'(2): d_q.far_hi    <= mem_rdata;
                            IDX_W'(3): d_q.near_addr <= mem_rdata;
                            IDX_W'(4): d_q.bytes     <= mem_rdata & BYTE_MASK;
                            default:   d_q.ctl       <= mem_rdata;
                        endcase
                        if (!en_i) begin
                            st_q <= ST_IDLE;
                        end else if (widx_q == LAST_IDX) begin
                            widx_q <= '0;
                            st_q   <= (d_q.bytes == '0) ? ST_RETIRE : ST_SRC;
                        end else begin
                            widx_q <= widx_q + IDX_W'(1);
                        end
                    end
                end
                ST_SRC: begin
                    if (bad) begin
                        st_q <= ST_IDLE;
                    end else if (ok) begin
                        hold_q <= mem_rdata;
                        st_q   <= en_i ? ST_DST : ST_IDLE;
                    end
                end
                ST_DST: begin
                    if (bad) begin
                        st_q <= ST_IDLE;
                    end else if (ok) begin
                        d_q.far_lo    <= d_q.far_lo + WORD_W'(4);
                        d_q.near_addr <= d_q.near_addr + WORD_W'(4);
                        d_q.bytes     <= d_q.bytes - WORD_W'(4);
                        if (!en_i)
                            st_q <= ST_IDLE;
                        else if (d_q.bytes == WORD_W'(4))
                            st_q <= ST_RETIRE;
                        else
                            st_q <= ST_SRC;
                    end
                end
                ST_RETIRE: begin
                    if ((d_q.link == '0) || !en_i) begin
                        st_q <= ST_IDLE;
                    end else begin
                        cur_q  <= d_q.link;
                        widx_q <= '0;
                        st_q   <= ST_FETCH;
                    end
                end
                ST_RELINK: begin
                    if (bad) begin
                        st_q <= ST_IDLE;
                    end else if (ok) begin
                        d_q.link <= mem_rdata;
                        if ((mem_rdata != '0) && en_i) begin
                            cur_q  <= mem_rdata;
                            widx_q <= '0;
                            st_q   <= ST_FETCH;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (st_q != ST_IDLE);
    assign desc_o = d_q;
    assign cur_o  = cur_q;

    // R12: an open request keeps its address and direction
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack && !mem_err |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R9: an error response leaves the channel idle
    assert_err_halt_R9: assert property (@(posedge clk) disable iff (rst)
        bad |=> !busy_o);

    // R5: no data read is issued with an empty count
    assert_nonzero_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SRC) |-> (d_q.bytes != '0));

    // R2: a start with a non-zero link fetches from that link address
    assert_start_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) && start_i && (d_q.link != '0)
        |=> mem_req && !mem_we && !mem_space && (mem_addr == $past(d_q.link)));

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              busy_i,
    input  flag_set_t         set_i,
    input  desc_t             desc_i,
    input  logic [WORD_W-1:0] cur_i,
    output logic              en_o,
    output logic              start_o,
    output logic              resume_o,
    output logic              link_wr_o
);

    logic      en_q;
    flag_set_t fl_q;
    flag_set_t clr;
    logic      ctrl_wr, stat_wr;

    assign ctrl_wr = reg_we && (reg_addr == RG_CTRL);
    assign stat_wr = reg_we && (reg_addr == RG_STAT);

    assign start_o   = ctrl_wr && reg_wdata[CB_EN] && !en_q && !busy_i;
    assign resume_o  = ctrl_wr && reg_wdata[CB_EN] && reg_wdata[CB_RESUME] && en_q && !busy_i;
    assign link_wr_o = reg_we && (reg_addr == RG_LINK) && !busy_i;

    always_comb begin
        clr       = '0;
        clr.tabt  = stat_wr && reg_wdata[SB_TABT];
        clr.mabt  = stat_wr && reg_wdata[SB_MABT];
        clr.iabt  = stat_wr && reg_wdata[SB_IABT];
        clr.chain = stat_wr && reg_wdata[SB_CHAIN];
        clr.xfer  = stat_wr && reg_wdata[SB_XFER];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            fl_q <= '0;
        end else begin
            if (ctrl_wr)
                en_q <= reg_wdata[CB_EN];
            fl_q <= set_i | (fl_q & ~clr);
        end
    end

    always_comb begin
        unique case (reg_addr)
            RG_CTRL:  reg_rdata = {{(WORD_W-1){1'b0}}, en_q};
            RG_STAT:  reg_rdata = pack_status(fl_q, busy_i);
            RG_CUR:   reg_rdata = cur_i;
            RG_LINK:  reg_rdata = desc_i.link;
            RG_FARLO: reg_rdata = desc_i.far_lo;
            RG_FARHI: reg_rdata = desc_i.far_hi;
            RG_NEAR:  reg_rdata = desc_i.near_addr;
            RG_BYTES: reg_rdata = desc_i.bytes;
            RG_DCTL:  reg_rdata = desc_i.ctl;
            default:  reg_rdata = '0;
        endcase
    end

    assign en_o = en_q;
    assign irq  = |fl_q;

    // R10: a set chain-end flag survives until a write of 1 clears it
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        fl_q.chain && !(stat_wr && reg_wdata[SB_CHAIN]) |=> fl_q.chain);

    // R7: reaching the end of the chain leaves the engine idle
    assert_chain_idle_R7: assert property (@(posedge clk) disable iff (rst)
        set_i.chain |=> !busy_i);

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_space,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic        mem_err,
    input  logic [1:0]  mem_err_kind,
    input  logic [31:0] mem_rdata
);

    logic              en, start, resume, link_wr, busy;
    flag_set_t         set_flags;
    desc_t             desc;
    logic [WORD_W-1:0] cur;

    dmac_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .busy_i    (busy),
        .set_i     (set_flags),
        .desc_i    (desc),
        .cur_i     (cur),
        .en_o      (en),
        .start_o   (start),
        .resume_o  (resume),
        .link_wr_o (link_wr)
    );

    dmac_seq #(.CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en),
        .start_i      (start),
        .resume_i     (resume),
        .link_wr_i    (link_wr),
        .link_wdata_i (reg_wdata),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_space    (mem_space),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_err      (mem_err),
        .mem_err_kind (mem_err_kind),
        .mem_rdata    (mem_rdata),
        .busy_o       (busy),
        .set_o        (set_flags),
        .desc_o       (desc),
        .cur_o        (cur)
    );

endmodule

// File: tb/dmac_engine_tb_top.sv
module dmac_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we, mem_space;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [1:0]  mem_err_kind = '0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] lmem [256];
    logic [31:0] rmem [256];

    logic        inj_on = 1'b0;
    logic [31:0] inj_addr = '0;
    logic [1:0]  inj_kind = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dmac_engine dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_err_kind(mem_err_kind), .mem_rdata(mem_rdata)
    );

    // memory responder: answers each request one cycle after it is seen
    always @(posedge clk) begin
        if (mem_req && !mem_ack && !mem_err) begin
            if (inj_on && mem_space && (mem_addr == inj_addr)) begin
                mem_err      <= 1'b1;
                mem_err_kind <= inj_kind;
            end else begin
                mem_ack <= 1'b1;
                if (mem_space) mem_rdata <= rmem[mem_addr[9:2]];
                else           mem_rdata <= lmem[mem_addr[9:2]];
                if (mem_we) begin
                    if (mem_space) rmem[mem_addr[9:2]] <= mem_wdata;
                    else           lmem[mem_addr[9:2]] <= mem_wdata;
                end
            end
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(string tag);
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(4'd1, s);
            if (!s[10]) return;
        end
        chk({tag, " idle timeout"}, 32'd1, 32'd0);
    endtask

    task automatic put_desc(int base, logic [31:0] link, logic [31:0] far,
                            logic [31:0] near, logic [31:0] bytes, logic [31:0] ctl);
        lmem[(base >> 2) + 0] = link;
        lmem[(base >> 2) + 1] = far;
        lmem[(base >> 2) + 2] = 32'h0;
        lmem[(base >> 2) + 3] = near;
        lmem[(base >> 2) + 4] = bytes;
        lmem[(base >> 2) + 5] = ctl;
    endtask

    task automatic finish_test();
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h32C);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd0, v); chk("R1 ctrl after reset", v, 32'h0);
        rd(4'd1, v); chk("R1 status after reset", v, 32'h0);
        chk("R1 irq after reset", {31'd0, irq}, 32'h0);
        chk("R1 mem_req after reset", {31'd0, mem_req}, 32'h0);
    endtask

    task automatic t_far_to_near();
        logic [31:0] v;
        put_desc(32'h100, 32'h0, 32'h10, 32'h200, 32'd12, 32'h16);
        for (int i = 0; i < 3; i++) lmem[8'h80 + i] = 32'h0;
        wr(4'd3, 32'h100);
        wr(4'd0, 32'h1);
        wait_idle("R2");
        for (int i = 0; i < 3; i++)
            chk("R3 far to near data", lmem[8'h80 + i], 32'hA5000000 + 32'(4 + i));
        rd(4'd1, v); chk("R6 R7 status after single record", v, 32'h300);
        chk("R10 irq with flags", {31'd0, irq}, 32'h1);
        rd(4'd2, v); chk("R11 current record", v, 32'h100);
        rd(4'd7, v); chk("R11 remaining bytes", v, 32'h0);
        rd(4'd6, v); chk("R11 near address advanced", v, 32'h20C);
        rd(4'd4, v); chk("R11 far address advanced", v, 32'h1C);
        wr(4'd1, 32'h300);
        rd(4'd1, v); chk("R10 status cleared by write", v, 32'h0);
        chk("R10 irq cleared", {31'd0, irq}, 32'h0);
        finish_test();
    endtask

    task automatic t_chain_near_to_far();
        logic [31:0] v;
        put_desc(32'h100, 32'h120, 32'h40, 32'h240, 32'd40, 32'h07);
        put_desc(32'h120, 32'h0, 32'h80, 32'h280, 32'd8, 32'h06);
        for (int i = 0; i < 10; i++) lmem[8'h90 + i] = 32'h11110000 + 32'(i);
        rmem[8'h20] = 32'hBEEF0001; rmem[8'h21] = 32'hBEEF0002;
        wr(4'd3, 32'h100);
        wr(4'd0, 32'h1);
        repeat (20) @(negedge clk);
        rd(4'd1, v); chk("R11 active bit while running", {31'd0, v[10]}, 32'h1);
        wr(4'd3, 32'h0);
        wait_idle("R7");
        for (int i = 0; i < 10; i++)
            chk("R3 near to far data", rmem[8'h10 + i], 32'h11110000 + 32'(i));
        chk("R7 linked record data 0", lmem[8'hA0], 32'hBEEF0001);
        chk("R7 linked record data 1", lmem[8'hA1], 32'hBEEF0002);
        rd(4'd1, v); chk("R6 no transfer flag without enable bit", v, 32'h100);
        rd(4'd2, v); chk("R11 link write ignored, second record reached", v, 32'h120);
        finish_test();
    endtask

    task automatic t_mem_to_mem();
        lmem[8'hB0] = 32'hC0DE0001; lmem[8'hB1] = 32'hC0DE0002;
        lmem[8'hB8] = 32'h0; lmem[8'hB9] = 32'h0;
        rmem[8'hB0] = 32'hBAD00001; rmem[8'hB1] = 32'hBAD00002;
        put_desc(32'h140, 32'h0, 32'h2C0, 32'h2E0, 32'd8, 32'h46);
        wr(4'd3, 32'h140);
        wr(4'd0, 32'h1);
        wait_idle("R4");
        chk("R4 near space copy 0", lmem[8'hB8], 32'hC0DE0001);
        chk("R4 near space copy 1", lmem[8'hB9], 32'hC0DE0002);
        chk("R4 far space untouched", rmem[8'hB8], 32'hA50000B8);
        finish_test();
    endtask

    task automatic t_count();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) lmem[8'hC0 + i] = 32'hDEAD0000;
        put_desc(32'h100, 32'h120, 32'h140, 32'h300, 32'hFF00000E, 32'h16);
        put_desc(32'h120, 32'h0, 32'h150, 32'h310, 32'h03000002, 32'h16);
        wr(4'd3, 32'h100);
        wr(4'd0, 32'h1);
        wait_idle("R5");
        for (int i = 0; i < 3; i++)
            chk("R5 truncated count copies three words", lmem[8'hC0 + i], 32'hA5000000 + 32'(8'h50 + i));
        chk("R5 fourth word untouched", lmem[8'hC3], 32'hDEAD0000);
        chk("R5 zero count moves nothing", lmem[8'hC4], 32'h5A0000C4);
        rd(4'd7, v); chk("R5 zero count kept", v, 32'h0);
        rd(4'd1, v); chk("R6 transfer flag on zero count record", v, 32'h300);
        finish_test();
    endtask

    task automatic t_resume();
        logic [31:0] v;
        lmem[8'hC8] = 32'h0; lmem[8'hC9] = 32'h0;
        put_desc(32'h160, 32'h0, 32'hC0, 32'h320, 32'd4, 32'h06);
        wr(4'd3, 32'h160);
        wr(4'd0, 32'h1);
        wait_idle("R8");
        chk("R8 first record copied", lmem[8'hC8], 32'hA5000030);
        wr(4'd1, 32'h100);
        wr(4'd0, 32'h3);
        wait_idle("R8");
        rd(4'd1, v); chk("R8 resume with zero link sets chain end", v, 32'h100);
        chk("R8 nothing copied on empty resume", lmem[8'hC9], 32'h0);
        wr(4'd1, 32'h100);
        put_desc(32'h180, 32'h0, 32'hC4, 32'h324, 32'd4, 32'h16);
        lmem[8'h58] = 32'h180;
        wr(4'd0, 32'h3);
        wait_idle("R8");
        chk("R8 appended record copied", lmem[8'hC9], 32'hA5000031);
        rd(4'd1, v); chk("R8 status after resume", v, 32'h300);
        rd(4'd2, v); chk("R8 current record after resume", v, 32'h180);
        finish_test();
    endtask

    task automatic t_error();
        logic [31:0] v;
        logic [31:0] expv [3];
        expv[0] = 32'h8; expv[1] = 32'h4; expv[2] = 32'h20;
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 4; i++) lmem[8'hD0 + i] = 32'h0;
            put_desc(32'h1A0, 32'h1C0, 32'hE0, 32'h340, 32'd16, 32'h16);
            inj_on = 1'b1; inj_addr = 32'hE8; inj_kind = 2'(k);
            wr(4'd3, 32'h1A0);
            wr(4'd0, 32'h1);
            wait_idle("R9");
            inj_on = 1'b0;
            rd(4'd1, v); chk("R9 error kind flag, active clear", v, expv[k]);
            chk("R9 irq on error", {31'd0, irq}, 32'h1);
            chk("R9 words before error copied", lmem[8'hD1], 32'hA5000039);
            chk("R9 word at error not written", lmem[8'hD2], 32'h0);
            rd(4'd2, v); chk("R9 link not followed", v, 32'h1A0);
            finish_test();
        end
    endtask

    task automatic t_disable();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) lmem[8'hE0 + i] = 32'h0;
        put_desc(32'h1E0, 32'h100, 32'h100, 32'h380, 32'd64, 32'h16);
        wr(4'd3, 32'h1E0);
        wr(4'd0, 32'h1);
        repeat (20) @(negedge clk);
        wr(4'd0, 32'h0);
        wait_idle("R13");
        rd(4'd1, v); chk("R13 stop sets no flag", v, 32'h0);
        chk("R13 last word not copied", lmem[8'hEF], 32'h0);
        rd(4'd2, v); chk("R13 stays on stopped record", v, 32'h1E0);
        repeat (4) @(negedge clk);
        chk("R12 no request after stop", {31'd0, mem_req}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            lmem[i] = 32'h5A000000 + 32'(i);
            rmem[i] = 32'hA5000000 + 32'(i);
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_far_to_near();
        t_chain_near_to_far();
        t_mem_to_mem();
        t_count();
        t_resume();
        t_error();
        t_disable();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule